// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A read or write command pulses the start strobe together with the column it names. From the next clock the block presents one column per cycle, flagged valid, until the programmed number of beats has been issued. The block samples the burst length code and the ordering select at that start. Later changes on those inputs do not affect the burst in progress.

Two orderings are offered. In sequential order the low bits of the column count upward and wrap inside an aligned block of the burst length. In interleaved order those low bits are the start column XORed with the beat index. A full-page code runs through the whole 256-column row and keeps going until a stop or a new start arrives. A stop input cuts a burst short. A new start replaces any running burst at once, so a fresh column may be issued on every clock.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and on the first clock after it, `valid_o` and `last_o` are low.
- R2: On the cycle after `start_i` is sampled high, `valid_o` is high and `col_o` equals the sampled `start_col_i`.
- R3: `len_code_i` selects the burst length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, and 4 to 6 give 1 beat. `valid_o` stays high for exactly that many cycles. `last_o` is high on the final beat only.
- R4: With `order_il_i` = 0, the low log2(length) bits of `col_o` advance by one per beat modulo the length. The upper bits keep the start value.
- R5: With `order_il_i` = 1, the low log2(length) bits of `col_o` on beat i equal the start column's low bits XOR i. The upper bits keep the start value.
- R6: Code 7 selects a full-page burst. `col_o` advances by one per beat modulo 256, whatever `order_il_i` is. `valid_o` stays high until a stop or a new start, and `last_o` never goes high.
- R7: `stop_i` sampled high during a burst, without `start_i`, makes `valid_o` low on the next cycle. When no burst is running, `stop_i` has no effect.
- R8: `start_i` during a burst restarts the sequence at once from the new column. When `start_i` and `stop_i` are sampled together, the start wins.
- R9: Changes on `len_code_i` and `order_il_i` between starts do not alter the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything is sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe issued with a read or write command |
| start_col_i | input | 8 | First column of the burst |
| len_code_i | input | 3 | Burst length code, sampled at start |
| order_il_i | input | 1 | 0 selects sequential order, 1 selects interleaved; sampled at start |
| stop_i | input | 1 | Ends the running burst |
| col_o | output | 8 | Column address of the current beat |
| valid_o | output | 1 | A beat is presented this cycle |
| last_o | output | 1 | The current beat is the final beat of a bounded burst |

## Verification
The bench builds the block with its default parameters: an 8-bit column and a maximum bounded burst of 8 beats. With these values every length code, both orderings and a complete 256-column full-page wrap can be reached within a few hundred cycles. The directed start columns sit close to block boundaries and row ends, so that each wrap is exercised. A long stretch of random starts, stops and mode changes follows, checked against a behavioural model on every clock. This stretch covers restarts on the last beat, starts and stops in the same cycle, and stops while idle.

// File: rtl/burst_seq_pkg.sv
`timescale 1ns/1ps
package burst_seq_pkg;
  localparam logic [2:0] LEN_FULL_CODE = 3'd7;

  typedef struct packed {
    logic [2:0] code;
    logic       il;
  } burst_mode_t;
endpackage

// File: rtl/burst_len_decode.sv
`timescale 1ns/1ps
module burst_len_decode
  import burst_seq_pkg::*;
#(
  parameter int COL_W      = 8,
  parameter int BL_MAX_LOG = 3
) (
  input  logic [2:0]       code_i,
  output logic [COL_W-1:0] mask_o,
  output logic             full_o
);
  localparam int NCODE = BL_MAX_LOG + 1;

  logic [COL_W-1:0] mask_tab [NCODE];

  genvar g;
  generate
    for (g = 0; g < NCODE; g++) begin : g_mask
      assign mask_tab[g] = COL_W'((1 << g) - 1);
    end
  endgenerate

  always_comb begin
    full_o = (code_i == LEN_FULL_CODE);
    mask_o = '0;
    if (full_o) begin
      mask_o = '1;
    end else begin
      for (int k = 0; k < NCODE; k++) begin
        if (32'(code_i) == k) mask_o = mask_tab[k];
      end
    end
  end
endmodule

// File: rtl/burst_col_gen.sv
`timescale 1ns/1ps
module burst_col_gen #(
  parameter int COL_W = 8
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             il_i,
  output logic [COL_W-1:0] col_o
);
  logic [COL_W-1:0] seq_sum;
  logic [COL_W-1:0] il_mix;

  assign seq_sum = base_i + beat_i;
  assign il_mix  = base_i ^ beat_i;

  genvar b;
  generate
    for (b = 0; b < COL_W; b++) begin : g_bit
      always_comb begin
        if (!mask_i[b])  col_o[b] = base_i[b];
        else if (il_i)   col_o[b] = il_mix[b];
        else             col_o[b] = seq_sum[b];
      end
    end
  endgenerate
endmodule

// File: rtl/burst_beat_ctrl.sv
`timescale 1ns/1ps
module burst_beat_ctrl
  import burst_seq_pkg::*;
#(
  parameter int COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  burst_mode_t      mode_i,
  input  logic             stop_i,
  input  logic             last_i,
  output logic             active_q,
  output logic [COL_W-1:0] base_q,
  output logic [COL_W-1:0] beat_q,
  output burst_mode_t      mode_q
);
  logic             active_d;
  logic [COL_W-1:0] beat_d;
  logic             ld_en;
  logic             beat_en;

  always_comb begin
    ld_en    = start_i;
    beat_en  = 1'b0;
    active_d = active_q;
    beat_d   = beat_q;
    if (start_i) begin
      active_d = 1'b1;
      beat_d   = '0;
      beat_en  = 1'b1;
    end else if (stop_i) begin
      active_d = 1'b0;
    end else if (active_q) begin
      if (last_i) begin
        active_d = 1'b0;
      end else begin
        beat_d  = beat_q + 1'b1;
        beat_en = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       beat_q <= '0;
    else if (beat_en) beat_q <= beat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      mode_q <= '0;
    end else if (ld_en) begin
      base_q <= start_col_i;
      mode_q <= mode_i;
    end
  end
endmodule

// File: rtl/burst_col_seq.sv
`timescale 1ns/1ps
module burst_col_seq
  import burst_seq_pkg::*;
#(
  parameter int COL_W      = 8,
  parameter int BL_MAX_LOG = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [2:0]       len_code_i,
  input  logic             order_il_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  burst_mode_t      mode_in;
  burst_mode_t      mode_q;
  logic             active_q;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] beat_q;
  logic [COL_W-1:0] mask_w;
  logic             full_w;
  logic             last_w;

  assign mode_in.code = len_code_i;
  assign mode_in.il   = order_il_i;

  burst_len_decode #(.COL_W(COL_W), .BL_MAX_LOG(BL_MAX_LOG)) u_dec (
    .code_i (mode_q.code),
    .mask_o (mask_w),
    .full_o (full_w)
  );

  assign last_w = active_q && !full_w && (beat_q == mask_w);

  burst_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .mode_i      (mode_in),
    .stop_i      (stop_i),
    .last_i      (last_w),
    .active_q    (active_q),
    .base_q      (base_q),
    .beat_q      (beat_q),
    .mode_q      (mode_q)
  );

  burst_col_gen #(.COL_W(COL_W)) u_gen (
    .base_i (base_q),
    .beat_i (beat_q),
    .mask_i (mask_w),
    .il_i   (mode_q.il && !full_w),
    .col_o  (col_o)
  );

  assign valid_o = active_q;
  assign last_o  = last_w;
endmodule

// File: rtl/burst_col_seq_chk.sv
`timescale 1ns/1ps
module burst_col_seq_chk #(
  parameter int COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o,
  input logic             full_w
);
  AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o && col_o == $past(start_col_i)));  // R2

  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);  // R3

  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (last_o && !start_i) |=> !valid_o);  // R3

  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_w && !start_i && !stop_i) |=>
      (valid_o && col_o == COL_W'($past(col_o) + 1)));  // R6

  AST_FULL_NO_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && full_w) |-> !last_o);  // R6

  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !start_i) |=> !valid_o);  // R7
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .last_o      (last_o),
  .full_w      (full_w)
);

// File: tb/burst_col_seq_tb.sv
`timescale 1ns/1ps
module burst_col_seq_tb;
  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [7:0] start_col_i;
  logic [2:0] len_code_i;
  logic       order_il_i;
  logic       stop_i;
  logic [7:0] col_o;
  logic       valid_o;
  logic       last_o;

  int    n_checks = 0;
  int    n_fails  = 0;
  string cur_req  = "R1";
  bit    cmp_on   = 0;
  bit    done     = 0;

  // behavioural reference
  bit m_act;
  int m_base, m_beat, m_len, m_il;

  burst_col_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
    .len_code_i(len_code_i), .order_il_i(order_il_i), .stop_i(stop_i),
    .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int code_len(input int c);
    if (c <= 3) return 1 << c;
    if (c == 7) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_act = 0; m_base = 0; m_beat = 0; m_len = 1; m_il = 0;
    end else if (start_i) begin
      m_act = 1; m_base = start_col_i; m_beat = 0;
      m_len = code_len(len_code_i); m_il = order_il_i;
    end else if (stop_i) begin
      m_act = 0;
    end else if (m_act) begin
      if (m_len != 0 && m_beat == m_len - 1) m_act = 0;
      else m_beat = (m_beat + 1) % 256;
    end
  end

  function automatic int exp_col();
    int lo;
    if (m_len == 0) return (m_base + m_beat) % 256;
    lo = m_base % m_len;
    if (m_il != 0) lo = lo ^ m_beat;
    else           lo = (lo + m_beat) % m_len;
    return m_base - (m_base % m_len) + lo;
  endfunction

  task automatic check1(input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", cur_req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on) begin
      check1("valid", int'(valid_o), int'(m_act));
      check1("last", int'(last_o),
             int'(m_act && m_len != 0 && m_beat == m_len - 1));
      if (m_act) check1("col", int'(col_o), exp_col());
    end
  end

  task automatic step(input bit s, input int col, input int code, input bit il, input bit stp);
    @(negedge clk);
    start_i = s; start_col_i = 8'(col); len_code_i = 3'(code);
    order_il_i = il; stop_i = stp;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0);
  endtask

  task automatic burst(input int col, input int code, input bit il, input int wait_n);
    step(1, col, code, il, 0);
    idle(wait_n);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #1600000;
    n_fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    rst_n = 0; start_i = 0; start_col_i = 0; len_code_i = 0; order_il_i = 0; stop_i = 0;
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check1("reset valid", int'(valid_o), 0);
    check1("reset last", int'(last_o), 0);
    rst_n = 1;
    cmp_on = 1;
    idle(2);

    cur_req = "R2";
    burst(8'h5C, 3, 0, 10);
    cur_req = "R3";
    for (int c = 0; c < 7; c++) burst(8'h13 + c, c, 0, 10);
    cur_req = "R4";
    burst(8'h35, 3, 0, 10);
    burst(8'hFE, 2, 0, 6);
    burst(8'h0F, 1, 0, 4);
    cur_req = "R5";
    burst(8'h35, 3, 1, 10);
    burst(8'h1B, 2, 1, 6);
    burst(8'hFF, 3, 1, 10);
    cur_req = "R6";
    step(1, 8'hFA, 7, 0, 0); idle(300); step(0, 0, 0, 0, 1); idle(3);
    step(1, 8'h03, 7, 1, 0); idle(40);  step(0, 0, 0, 0, 1); idle(3);
    cur_req = "R7";
    step(1, 8'h40, 3, 0, 0); idle(3); step(0, 0, 0, 0, 1); idle(3);
    step(0, 0, 0, 0, 1); idle(2);
    cur_req = "R8";
    step(1, 8'h20, 3, 0, 0); idle(2); step(1, 8'h77, 2, 1, 0); idle(6);
    step(1, 8'h10, 3, 0, 0); idle(1); step(1, 8'h91, 3, 0, 1); idle(10);
    step(1, 8'h08, 1, 0, 0); step(0, 0, 0, 0, 0); step(1, 8'h09, 1, 0, 0); idle(4);
    cur_req = "R9";
    step(1, 8'h66, 2, 0, 0);
    step(0, 0, 7, 1, 0); step(0, 0, 0, 1, 0); idle(5);

    cur_req = "R8";
    for (int k = 0; k < 3000; k++) begin
      step(($urandom % 5) == 0, $urandom % 256, $urandom % 8,
           1'($urandom % 2), ($urandom % 9) == 0);
    end
    idle(3);
    finish_run();
  end
endmodule